// File: doc/BRIEF.md
# Bit-Selection Block-Enable Generator for a Partitioned Route Lookup

This block sits in front of a ternary route table that is cut into fixed-size blocks. Searching fewer blocks draws less power. Each lookup presents a 32-bit destination address. Three programmable bit-position selectors pick three address bits, and these bits form a 3-bit bucket number. A programmable table turns that bucket number into a mask of blocks, because one bucket can span several blocks. A fixed set of blocks holds the prefixes that are too short or too long to be bucketed. These blocks are ORed into every result. The output is the block-enable mask that the search stage applies to its next search. A separate write port loads the selectors and the bucket table.

Selector positions count from the most significant address bit, which is position 0. Every position is confined to the first 16 address bits. A written value above 15 is clamped to 15 when it is stored. After reset the selectors point at positions 13, 14 and 15, which are the last three bits of the upper half of the address.

A small state machine records what the previous cycle did and has three named states. ST_IDLE means no lookup and no configuration write took effect. ST_SEARCH means a lookup was accepted. ST_CONFIG means a configuration write took effect. The next state does not depend on the current state. Every state goes to ST_SEARCH when `lk_valid` is high. Otherwise it goes to ST_CONFIG when `cfg_we` is high. Otherwise it goes to ST_IDLE. The search outputs are valid while the machine is in ST_SEARCH. Configuration is only ever changed on a cycle without a lookup.

Top module: `lk_bitsel_ctrl`

## Requirements
- R1: After reset `srch_valid` is 0 and `srch_blk_en` is zero. The selectors start at positions 13, 14 and 15 for selectors 0, 1 and 2. Each bucket-table entry k starts as the mask with only block k set.
- R2: A selector write with a value above 15 in `cfg_wdata[4:0]` stores 15. Any value up to 15 is stored unchanged.
- R3: The bucket number is {A[s0], A[s1], A[s2]}, with selector 0 as its most significant bit. A[p] is address bit `lk_addr[31-p]`, so position 0 is the MSB. The bucket number appears on `srch_bucket`.
- R4: While `srch_valid` is high, every block in the always-on set (blocks 14 and 15, mask 16'hC000) is set in `srch_blk_en`. This holds whatever the bucket is.
- R5: `srch_blk_en` equals the table entry of the looked-up bucket ORed with the always-on set.
- R6: `srch_valid`, `srch_blk_en` and `srch_bucket` are updated at the clock edge that accepts a lookup, so they are due one cycle after `lk_valid`. On a cycle that follows no lookup, `srch_valid` is 0 and `srch_blk_en` and `srch_bucket` are zero.
- R7: The configuration address map is as follows. `cfg_addr` 0, 1 and 2 write selectors 0, 1 and 2. `cfg_addr` 8+k writes the table entry of bucket k with `cfg_wdata`. A write is used by a lookup presented in the very next cycle.
- R8: A configuration write presented in the same cycle as a lookup is dropped. That lookup and later ones see the old configuration.
- R9: Writes to `cfg_addr` 3 to 7 change neither the selectors nor the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Destination address of the lookup |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| srch_valid | output | 1 | Block-enable result is valid |
| srch_blk_en | output | 16 | Blocks to enable for the search |
| srch_bucket | output | 3 | Bucket number of the lookup |

## Verification
Every lookup result is due at the first clock edge after `lk_valid` is presented. A configuration write also lands at the first edge, so a lookup in the next cycle already sees it. The bench drives each cycle's inputs, waits for that edge, and samples 1 ns later. At that point it compares against a model that was updated only for writes that took effect before the edge. It clears the idle outputs and drops a colliding write in the model just as R6 and R8 require. This keeps the expected value of every cycle tied to the configuration that the design held when the lookup was accepted.

// File: rtl/lk_bitsel_pkg.sv
`timescale 1ns/1ps
package lk_bitsel_pkg;

    // What the previous cycle did
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_CONFIG = 2'd2
    } lk_state_e;

endpackage

// File: rtl/lk_bitsel_cfg.sv
`timescale 1ns/1ps
// Selector registers (clamped to the hash window) and bucket-to-block table
module lk_bitsel_cfg #(
    parameter int NSEL   = 3,
    parameter int POS_W  = 5,
    parameter int WINDOW = 16,
    parameter int NBLK   = 16,
    parameter int NBKT   = 1 << NSEL,
    parameter int CFG_AW = $clog2(2 * NBKT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CFG_AW-1:0]        wr_addr,
    input  logic [NBLK-1:0]          wr_data,
    output logic [NSEL*POS_W-1:0]    sel_flat,
    output logic [NBKT*NBLK-1:0]     tbl_flat
);

    localparam logic [POS_W-1:0] POS_MAX = POS_W'(WINDOW - 1);

    logic [POS_W-1:0] wr_pos;
    assign wr_pos = (wr_data[POS_W-1:0] > POS_MAX) ? POS_MAX : wr_data[POS_W-1:0];

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        localparam logic [POS_W-1:0] POS_RST = POS_W'(WINDOW - NSEL + i);
        logic [POS_W-1:0] pos_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pos_q <= POS_RST;
            end else if (wr_en && (wr_addr == CFG_AW'(i))) begin
                pos_q <= wr_pos;
            end
        end
        assign sel_flat[i*POS_W +: POS_W] = pos_q;
    end

    for (genvar k = 0; k < NBKT; k++) begin : g_tbl
        localparam logic [NBLK-1:0] MASK_RST = NBLK'(1) << k;
        logic [NBLK-1:0] mask_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= MASK_RST;
            end else if (wr_en && (wr_addr == CFG_AW'(NBKT + k))) begin
                mask_q <= wr_data;
            end
        end
        assign tbl_flat[k*NBLK +: NBLK] = mask_q;
    end

endmodule

// File: rtl/lk_bitsel_extract.sv
`timescale 1ns/1ps
// Pulls the selected address bits together into a bucket number
module lk_bitsel_extract #(
    parameter int ADDR_W = 32,
    parameter int NSEL   = 3,
    parameter int POS_W  = 5
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NSEL*POS_W-1:0] sel_flat,
    output logic [NSEL-1:0]       bucket
);

    // Position 0 is the address MSB: reverse so a position indexes directly
    logic [ADDR_W-1:0] addr_rev;
    for (genvar j = 0; j < ADDR_W; j++) begin : g_rev
        assign addr_rev[j] = addr[ADDR_W-1-j];
    end

    for (genvar i = 0; i < NSEL; i++) begin : g_pick
        logic [POS_W-1:0] pos;
        assign pos = sel_flat[i*POS_W +: POS_W];
        assign bucket[NSEL-1-i] = addr_rev[pos];
    end

endmodule

// File: rtl/lk_bitsel_ctrl.sv
`timescale 1ns/1ps
// Top: bucket selection, block-enable generation and write gating
module lk_bitsel_ctrl
    import lk_bitsel_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              NSEL        = 3,
    parameter int              POS_W       = 5,
    parameter int              WINDOW      = 16,
    parameter int              NBLK        = 16,
    parameter logic [NBLK-1:0] ALWAYS_MASK = 16'hC000,
    localparam int             NBKT        = 1 << NSEL,
    localparam int             CFG_AW      = $clog2(2 * NBKT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [NBLK-1:0]   cfg_wdata,
    output logic              srch_valid,
    output logic [NBLK-1:0]   srch_blk_en,
    output logic [NSEL-1:0]   srch_bucket
);

    lk_state_e state_q, state_d;

    logic [NSEL*POS_W-1:0] sel_flat;
    logic [NBKT*NBLK-1:0]  tbl_flat;
    logic [NSEL-1:0]       bkt;
    logic [NBLK-1:0]       bkt_mask;
    logic                  wr_ok;

    // Next state: a lookup wins over a write in the same cycle
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_SEARCH, ST_CONFIG: begin
                if (lk_valid)    state_d = ST_SEARCH;
                else if (cfg_we) state_d = ST_CONFIG;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign wr_ok = (state_d == ST_CONFIG);

    lk_bitsel_cfg #(
        .NSEL(NSEL), .POS_W(POS_W), .WINDOW(WINDOW), .NBLK(NBLK),
        .NBKT(NBKT), .CFG_AW(CFG_AW)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .sel_flat (sel_flat),
        .tbl_flat (tbl_flat)
    );

    lk_bitsel_extract #(
        .ADDR_W(ADDR_W), .NSEL(NSEL), .POS_W(POS_W)
    ) u_ext (
        .addr     (lk_addr),
        .sel_flat (sel_flat),
        .bucket   (bkt)
    );

    assign bkt_mask = tbl_flat[int'(bkt)*NBLK +: NBLK];

    // Output process: result registered at the edge that accepts the lookup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srch_blk_en <= '0;
            srch_bucket <= '0;
        end else if (state_d == ST_SEARCH) begin
            srch_blk_en <= bkt_mask | ALWAYS_MASK;
            srch_bucket <= bkt;
        end else begin
            srch_blk_en <= '0;
            srch_bucket <= '0;
        end
    end

    assign srch_valid = (state_q == ST_SEARCH);

endmodule

// File: rtl/lk_bitsel_ctrl_chk.sv
`timescale 1ns/1ps
module lk_bitsel_ctrl_chk #(
    parameter int              NSEL        = 3,
    parameter int              POS_W       = 5,
    parameter int              WINDOW      = 16,
    parameter int              NBLK        = 16,
    parameter int              NBKT        = 8,
    parameter logic [NBLK-1:0] ALWAYS_MASK = 16'hC000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lk_valid,
    input logic                  cfg_we,
    input logic                  srch_valid,
    input logic [NBLK-1:0]       srch_blk_en,
    input logic [NSEL*POS_W-1:0] sel_flat,
    input logic [NBKT*NBLK-1:0]  tbl_flat
);

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> srch_valid);

    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!srch_valid && srch_blk_en == '0));

    a_r4_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |-> ((srch_blk_en & ALWAYS_MASK) == ALWAYS_MASK));

    a_r8_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lk_valid) |=> (sel_flat == $past(sel_flat) && tbl_flat == $past(tbl_flat)));

    for (genvar i = 0; i < NSEL; i++) begin : g_clamp
        a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            sel_flat[i*POS_W +: POS_W] <= POS_W'(WINDOW - 1));
    end

endmodule

bind lk_bitsel_ctrl lk_bitsel_ctrl_chk #(
    .NSEL(NSEL), .POS_W(POS_W), .WINDOW(WINDOW), .NBLK(NBLK),
    .NBKT(NBKT), .ALWAYS_MASK(ALWAYS_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .cfg_we      (cfg_we),
    .srch_valid  (srch_valid),
    .srch_blk_en (srch_blk_en),
    .sel_flat    (sel_flat),
    .tbl_flat    (tbl_flat)
);

// File: tb/lk_bitsel_ctrl_test.sv
`timescale 1ns/1ps
module lk_bitsel_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        srch_valid;
    logic [15:0] srch_blk_en;
    logic [2:0]  srch_bucket;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [15:0] ALWAYS = 16'hC000;

    int          m_sel [3];
    logic [15:0] m_tbl [8];

    always #4 clk = ~clk;

    lk_bitsel_ctrl uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .srch_valid(srch_valid), .srch_blk_en(srch_blk_en), .srch_bucket(srch_bucket)
    );

    function automatic logic [2:0] f_bucket(input logic [31:0] a);
        return {a[31-m_sel[0]], a[31-m_sel[1]], a[31-m_sel[2]]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, pass the edge, sample 1 ns later, then update the model
    task automatic cyc(input bit lv, input logic [31:0] a, input bit we,
                       input logic [3:0] wa, input logic [15:0] wd, input string req);
        logic [2:0]  eb;
        logic [15:0] em;
        lk_valid = lv; lk_addr = a; cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
        eb = f_bucket(a);
        em = m_tbl[eb] | ALWAYS;
        @(posedge clk); #1;
        if (lv) begin
            chk(srch_valid == 1'b1, req, "valid", 32'(srch_valid), 32'd1);
            chk(srch_bucket == eb, req, "bucket", 32'(srch_bucket), 32'(eb));
            chk(srch_blk_en == em, req, "blk_en", 32'(srch_blk_en), 32'(em));
        end else begin
            chk(srch_valid == 1'b0, req, "idle valid", 32'(srch_valid), 32'd0);
            chk(srch_blk_en == '0, req, "idle blk_en", 32'(srch_blk_en), 32'd0);
        end
        if (we && !lv) begin
            if (wa < 4'd3) m_sel[wa] = (wd[4:0] > 5'd15) ? 15 : int'(wd[4:0]);
            else if (wa >= 4'd8) m_tbl[wa-8] = wd;
        end
        lk_valid = 0; cfg_we = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) m_sel[i] = 13 + i;
        for (int k = 0; k < 8; k++) m_tbl[k] = 16'(1) << k;

        repeat (3) @(posedge clk);
        #1;
        chk(srch_valid == 0, "R1", "reset valid", 32'(srch_valid), 0);
        chk(srch_blk_en == 0, "R1", "reset blk_en", 32'(srch_blk_en), 0);
        rst_n = 1;

        // R1/R3/R4: default selectors take address bits 18..16 (LSB-0 numbering)
        for (int k = 0; k < 8; k++) cyc(1, 32'(k) << 16, 0, 0, 0, "R1");
        cyc(1, 32'hFFF8_FFFF, 0, 0, 0, "R3");
        // R6: idle cycle clears outputs
        cyc(0, 0, 0, 0, 0, "R6");

        // R2: clamp above window
        cyc(0, 0, 1, 4'd0, 16'd31, "R2");
        cyc(1, 32'h0001_0000, 0, 0, 0, "R2");
        cyc(0, 0, 1, 4'd1, 16'd16, "R2");
        cyc(1, 32'h0001_0000, 0, 0, 0, "R2");
        // R3: position 0 is the MSB; R7 write used in the next cycle
        cyc(0, 0, 1, 4'd0, 16'd0, "R7");
        cyc(1, 32'h8000_0000, 0, 0, 0, "R3");
        cyc(1, 32'h7FFF_FFFF, 0, 0, 0, "R3");
        // R5: table entries with several blocks
        cyc(0, 0, 1, 4'd12, 16'h0F0F, "R5");
        cyc(0, 0, 1, 4'd2, 16'd1, "R7");
        cyc(1, 32'h4000_0000, 0, 0, 0, "R5");
        // R8: collision drops the write
        cyc(1, 32'h0000_0000, 1, 4'd8, 16'h1234, "R8");
        cyc(1, 32'h0000_0000, 0, 0, 0, "R8");
        cyc(1, 32'h0000_0000, 1, 4'd0, 16'd5, "R8");
        cyc(1, 32'h8000_0000, 0, 0, 0, "R8");
        // R9: unmapped addresses
        for (int a = 3; a < 8; a++) cyc(0, 0, 1, 4'(a), 16'hFFFF, "R9");
        for (int k = 0; k < 8; k++)
            cyc(1, {k[2], 1'b0, k[1], 13'd0, k[0], 15'd0}, 0, 0, 0, "R9");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = $urandom % 8;
            if (r < 4)
                cyc(1, $urandom, ($urandom % 6) == 0, 4'($urandom), 16'($urandom), "R5");
            else if (r < 7)
                cyc(0, 0, 1, 4'($urandom), 16'($urandom), "R7");
            else
                cyc(0, $urandom, 0, 0, 0, "R6");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule